// File: doc/BRIEF.md
# Dual-mode programmable decimating FIR

This block is the final filter stage of a decimation chain. It keeps a bank of 96 signed 17-bit coefficients, loaded one at a time through a write port. It produces one output for every two input samples it accepts.

In single mode, one filter of up to 96 taps works on input 0 alone. In dual mode, the coefficient bank is split in two. The lower 48 coefficients filter input 0 and the upper 48 filter input 1, so the chosen tap count is shared equally between the two inputs.

When the filter is turned off, a fixed decimation path takes over. It simply forwards every second sample of each input. Filter results are rounded and then saturated back to the input data width.

Top module: `dual_mode_dec_fir`

## Requirements
- R1: During and after reset, the filter is off, the mode is single, and the tap count is 0. While reset is held, `out_valid`, `out0`, `out1` and `cfg_err` are all 0.
- R2: On a clock edge with `cfg_we` high, the configuration registers load `cfg_enable`, `cfg_dual` (0 = single, 1 = dual) and `cfg_taps`. On a clock edge with `coef_we` high, the coefficient at `coef_addr` is written, for addresses 0 to 95. A write to any address from 96 to 127 changes no coefficient and does not alias onto a lower one.
- R3: The first, third, fifth (and so on) sample accepted with `in_valid` after reset produce no output. Each second accepted sample raises `out_valid` for exactly one cycle, in the cycle after it is accepted. Idle cycles leave the sample history unchanged.
- R4: With the filter off, an output cycle carries the two input samples of its triggering beat unchanged: `out0` = `in0` and `out1` = `in1`.
- R5: In single mode, with the filter on, `out0` = Σ c[k]·x0[n−k] for k < T. Here T is the tap count limited to 96, and x0[n] is the sample of the triggering beat. `out1` is 0.
- R6: In dual mode, with the filter on, let H = floor(taps/2), limited to 48. Then `out0` = Σ c[k]·x0[n−k] and `out1` = Σ c[48+k]·x1[n−k], both for k < H.
- R7: In dual mode, an odd tap count is lowered to the next even value. One cycle after the registers hold dual mode with an odd count, `cfg_err` goes high and stays high until reset.
- R8: The accumulated sum is scaled down by 2^15, rounding half up: 2^14 is added before an arithmetic right shift of 15.
- R9: The rounded result saturates to the range −32768 to 32767.
- R10: Coefficients are 17-bit two's complement values, so −65536 to 65535 are all accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load the configuration registers |
| cfg_enable | input | 1 | 1 = programmable filter, 0 = fixed decimation path |
| cfg_dual | input | 1 | 0 = single mode, 1 = dual mode |
| cfg_taps | input | 7 | Active tap count |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 7 | Coefficient address |
| coef_data | input | 17 | Signed coefficient value |
| in_valid | input | 1 | Input beat strobe |
| in0 | input | 16 | Signed sample, input 0 |
| in1 | input | 16 | Signed sample, input 1 |
| out_valid | output | 1 | Output beat strobe |
| out0 | output | 16 | Signed result, input 0 |
| out1 | output | 16 | Signed result, input 1 |
| cfg_err | output | 1 | Sticky flag: odd tap count seen in dual mode |

## Verification
The hardest case to reach is the upper coefficient half feeding the second input. It only matters in dual mode, and only after enough samples have passed that the 48-deep history of input 1 holds independent data. The shared sample history also carries over from one configuration to the next. The stimulus therefore keeps a single running sample stream across sweeps of every tap count, from 1 to 97 in dual mode and from 1 to 96 in single mode, and the expected sums come from a history model in the bench that never resets. This puts both coefficient halves, all count limits and the odd-count rounding to an even value under real data. A second pass uses full-scale coefficients and data to drive the rounding and both saturation rails.

// File: rtl/dual_mode_dec_fir_pkg.sv
package dual_mode_dec_fir_pkg;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_DUAL   = 1'b1
  } fir_mode_e;

  // scale down by 2^frac, rounding half toward +inf
  function automatic longint round_half_up(input longint acc, input int frac);
    longint bias;
    bias = longint'(1) <<< (frac - 1);
    return (acc + bias) >>> frac;
  endfunction

  // clamp to signed range of 'width' bits
  function automatic longint clip_to(input longint v, input int width);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (width - 1)) - 1;
    lo = -(longint'(1) <<< (width - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/dual_mode_dec_fir_coef_mem.sv
module dual_mode_dec_fir_coef_mem #(
  parameter int NUM_TAPS = 96,
  parameter int COEF_W   = 17,
  parameter int ADDR_W   = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic signed [COEF_W-1:0] wdata,
  output logic signed [COEF_W-1:0] coef [NUM_TAPS]
);

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        coef[g] <= '0;
      else if (we && (addr == ADDR_W'(g)))
        coef[g] <= wdata;
    end
  end

endmodule

// File: rtl/dual_mode_dec_fir_delay.sv
module dual_mode_dec_fir_delay #(
  parameter int DEPTH  = 96,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] win [DEPTH]
);

  logic signed [DATA_W-1:0] hist [DEPTH-1];

  assign win[0] = din;

  for (genvar g = 0; g < DEPTH - 1; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        hist[g] <= '0;
      else if (shift)
        hist[g] <= (g == 0) ? din : hist[(g == 0) ? 0 : g - 1];
    end
    assign win[g + 1] = hist[g];
  end

endmodule

// File: rtl/dual_mode_dec_fir_mac.sv
module dual_mode_dec_fir_mac #(
  parameter int N      = 96,
  parameter int DATA_W = 16,
  parameter int COEF_W = 17,
  parameter int CNT_W  = 7,
  parameter int ACC_W  = 40
) (
  input  logic signed [DATA_W-1:0] win  [N],
  input  logic signed [COEF_W-1:0] coef [N],
  input  logic [CNT_W-1:0]         count,
  output logic signed [ACC_W-1:0]  acc
);

  always_comb begin
    acc = '0;
    for (int k = 0; k < N; k++) begin
      if (k < int'(count))
        acc = acc + ACC_W'(win[k]) * ACC_W'(coef[k]);
    end
  end

endmodule

// File: rtl/dual_mode_dec_fir.sv
module dual_mode_dec_fir
  import dual_mode_dec_fir_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 17,
  parameter int COEF_FRAC = 15,
  parameter int NUM_TAPS  = 96
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic                     cfg_enable,
  input  logic                     cfg_dual,
  input  logic [6:0]               cfg_taps,
  input  logic                     coef_we,
  input  logic [6:0]               coef_addr,
  input  logic signed [COEF_W-1:0] coef_data,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in0,
  input  logic signed [DATA_W-1:0] in1,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out0,
  output logic signed [DATA_W-1:0] out1,
  output logic                     cfg_err
);

  localparam int HALF   = NUM_TAPS / 2;
  localparam int CNT_W  = 7;
  localparam int ADDR_W = 7;
  localparam int ACC_W  = DATA_W + COEF_W + $clog2(NUM_TAPS);

  // configuration registers
  logic             en_r;
  fir_mode_e        mode_r;
  logic [CNT_W-1:0] taps_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r   <= 1'b0;
      mode_r <= MODE_SINGLE;
      taps_r <= '0;
    end else if (cfg_we) begin
      en_r   <= cfg_enable;
      mode_r <= fir_mode_e'(cfg_dual);
      taps_r <= cfg_taps;
    end
  end

  // named internal events
  logic dual_act;
  logic dual_odd;
  logic take_out;
  logic phase;

  assign dual_act = (mode_r == MODE_DUAL);
  assign dual_odd = dual_act & taps_r[0];
  assign take_out = in_valid & phase;

  // coefficient bank
  logic signed [COEF_W-1:0] coef_all [NUM_TAPS];
  logic signed [COEF_W-1:0] coef_hi  [HALF];

  dual_mode_dec_fir_coef_mem #(
    .NUM_TAPS(NUM_TAPS), .COEF_W(COEF_W), .ADDR_W(ADDR_W)
  ) u_coef (
    .clk(clk), .rst_n(rst_n), .we(coef_we),
    .addr(coef_addr), .wdata(coef_data), .coef(coef_all)
  );

  for (genvar g = 0; g < HALF; g++) begin : g_hi
    assign coef_hi[g] = coef_all[HALF + g];
  end

  // sample histories
  logic signed [DATA_W-1:0] win0 [NUM_TAPS];
  logic signed [DATA_W-1:0] win1 [HALF];

  dual_mode_dec_fir_delay #(.DEPTH(NUM_TAPS), .DATA_W(DATA_W)) u_hist0 (
    .clk(clk), .rst_n(rst_n), .shift(in_valid), .din(in0), .win(win0)
  );

  dual_mode_dec_fir_delay #(.DEPTH(HALF), .DATA_W(DATA_W)) u_hist1 (
    .clk(clk), .rst_n(rst_n), .shift(in_valid), .din(in1), .win(win1)
  );

  // active tap counts
  logic [CNT_W-1:0] cnt_single;
  logic [CNT_W-1:0] cnt_half;
  logic [CNT_W-1:0] cnt0;
  logic [CNT_W-1:0] cnt1;

  always_comb begin
    cnt_single = (int'(taps_r) > NUM_TAPS) ? CNT_W'(NUM_TAPS) : taps_r;
    cnt_half   = (int'(taps_r >> 1) > HALF) ? CNT_W'(HALF) : (taps_r >> 1);
    cnt0       = dual_act ? cnt_half : cnt_single;
    cnt1       = dual_act ? cnt_half : '0;
  end

  // dot products
  logic signed [ACC_W-1:0] acc0;
  logic signed [ACC_W-1:0] acc1;

  dual_mode_dec_fir_mac #(
    .N(NUM_TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W), .CNT_W(CNT_W), .ACC_W(ACC_W)
  ) u_mac0 (
    .win(win0), .coef(coef_all), .count(cnt0), .acc(acc0)
  );

  dual_mode_dec_fir_mac #(
    .N(HALF), .DATA_W(DATA_W), .COEF_W(COEF_W), .CNT_W(CNT_W), .ACC_W(ACC_W)
  ) u_mac1 (
    .win(win1), .coef(coef_hi), .count(cnt1), .acc(acc1)
  );

  // rounding and saturation
  logic signed [63:0] y0_full;
  logic signed [63:0] y1_full;

  assign y0_full = clip_to(round_half_up(longint'(acc0), COEF_FRAC), DATA_W);
  assign y1_full = clip_to(round_half_up(longint'(acc1), COEF_FRAC), DATA_W);

  // output stage and decimation phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= 1'b0;
      out_valid <= 1'b0;
      out0      <= '0;
      out1      <= '0;
    end else begin
      out_valid <= take_out;
      if (in_valid)
        phase <= ~phase;
      if (take_out) begin
        if (en_r) begin
          out0 <= y0_full[DATA_W-1:0];
          out1 <= dual_act ? y1_full[DATA_W-1:0] : '0;
        end else begin
          out0 <= in0;
          out1 <= in1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_err <= 1'b0;
    else if (dual_odd)
      cfg_err <= 1'b1;
  end

endmodule

module dual_mode_dec_fir_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in0,
  input logic signed [DATA_W-1:0] in1,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out0,
  input logic signed [DATA_W-1:0] out1,
  input logic                     cfg_err,
  input logic                     en_r,
  input logic                     dual_act,
  input logic [CNT_W-1:0]         taps_r
);

  // R3
  valid_after_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R4
  bypass_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(en_r)) |-> (out0 == $past(in0) && out1 == $past(in1)));

  // R5
  single_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(en_r) && !$past(dual_act)) |-> (out1 == '0));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(dual_act && taps_r[0]));

endmodule

bind dual_mode_dec_fir dual_mode_dec_fir_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in0(in0), .in1(in1),
  .out_valid(out_valid), .out0(out0), .out1(out1), .cfg_err(cfg_err),
  .en_r(en_r), .dual_act(dual_act), .taps_r(taps_r)
);

// File: tb/dual_mode_dec_fir_bench.sv
`timescale 1ns/1ps
module dual_mode_dec_fir_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_enable = 1'b0, cfg_dual = 1'b0;
  logic [6:0] cfg_taps = '0;
  logic coef_we = 1'b0;
  logic [6:0] coef_addr = '0;
  logic signed [16:0] coef_data = '0;
  logic in_valid = 1'b0;
  logic signed [15:0] in0 = '0, in1 = '0;
  logic out_valid;
  logic signed [15:0] out0, out1;
  logic cfg_err;

  always #2.5 clk = ~clk;

  dual_mode_dec_fir u_dual_mode_dec_fir (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
    .cfg_dual(cfg_dual), .cfg_taps(cfg_taps), .coef_we(coef_we),
    .coef_addr(coef_addr), .coef_data(coef_data), .in_valid(in_valid),
    .in0(in0), .in1(in1), .out_valid(out_valid), .out0(out0), .out1(out1),
    .cfg_err(cfg_err)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench model state
  longint bc [96];
  longint h0 [96];
  longint h1 [48];
  bit ph = 0;
  bit m_en = 0, m_dual = 0;
  int m_taps = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint scale_sat(input longint s);
    longint q, r;
    q = s + 16384;
    if (q >= 0) r = q / 32768;
    else        r = -((-q + 32767) / 32768);
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic longint rnd16();
    return longint'($signed(16'($urandom)));
  endfunction

  function automatic longint rnd17();
    return longint'($signed(17'($urandom)));
  endfunction

  task automatic cfg(input bit en, input bit dual, input int taps);
    @(negedge clk);
    cfg_we = 1; cfg_enable = en; cfg_dual = dual; cfg_taps = 7'(taps);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0;
    m_en = en; m_dual = dual; m_taps = taps;
  endtask

  task automatic wcoef(input int addr, input longint val);
    @(negedge clk);
    coef_we = 1; coef_addr = 7'(addr); coef_data = 17'(val);
    @(posedge clk);
    @(negedge clk);
    coef_we = 0;
    if (addr < 96) bc[addr] = val;
  endtask

  task automatic push(input longint a, input longint b, input string tag);
    longint e0, e1, s0, s1;
    int t, hh;
    for (int k = 95; k > 0; k--) h0[k] = h0[k-1];
    for (int k = 47; k > 0; k--) h1[k] = h1[k-1];
    h0[0] = a; h1[0] = b;
    s0 = 0; s1 = 0;
    if (!m_en) begin
      e0 = a; e1 = b;
    end else if (!m_dual) begin
      t = (m_taps > 96) ? 96 : m_taps;
      for (int k = 0; k < t; k++) s0 += bc[k] * h0[k];
      e0 = scale_sat(s0); e1 = 0;
    end else begin
      hh = m_taps / 2;
      if (hh > 48) hh = 48;
      for (int k = 0; k < hh; k++) begin
        s0 += bc[k] * h0[k];
        s1 += bc[48 + k] * h1[k];
      end
      e0 = scale_sat(s0); e1 = scale_sat(s1);
    end
    @(negedge clk);
    in_valid = 1; in0 = 16'(a); in1 = 16'(b);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    if (ph) begin
      chk(out_valid == 1'b1, {"R3 ", tag, " valid"}, longint'(out_valid), 1);
      chk(longint'(out0) == e0, {tag, " out0"}, longint'(out0), e0);
      chk(longint'(out1) == e1, {tag, " out1"}, longint'(out1), e1);
    end else begin
      chk(out_valid == 1'b0, {"R3 ", tag, " no output on first beat"}, longint'(out_valid), 0);
    end
    ph = ~ph;
  endtask

  initial begin
    for (int k = 0; k < 96; k++) begin bc[k] = 0; h0[k] = 0; end
    for (int k = 0; k < 48; k++) h1[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 0, "R1 out_valid", longint'(out_valid), 0);
    chk(out0 == 0 && out1 == 0, "R1 outputs", longint'(out0), 0);
    chk(cfg_err == 0, "R1 cfg_err", longint'(cfg_err), 0);
    rst_n = 1;

    // R1 filter off after reset: R4 bypass
    for (int i = 0; i < 8; i++) push(rnd16(), rnd16(), "R1 R4 bypass after reset");

    // R10 load full-range random coefficients
    for (int k = 0; k < 96; k++) wcoef(k, rnd17());

    // R5 single-mode sweep over every tap count
    for (int t = 1; t <= 96; t++) begin
      cfg(1, 0, t);
      for (int i = 0; i < 4; i++) push(rnd16(), rnd16(), "R5 single sweep");
    end
    cfg(1, 0, 127);
    for (int i = 0; i < 4; i++) push(rnd16(), rnd16(), "R5 count above 96");
    chk(cfg_err == 0, "R7 no error in single mode", longint'(cfg_err), 0);

    // R2 writes above the bank are dropped, no aliasing
    cfg(1, 0, 96);
    wcoef(96, 12345);
    wcoef(127, -999);
    wcoef(100, 4321);
    for (int i = 0; i < 6; i++) push(rnd16(), rnd16(), "R2 high address ignored");

    // R6 dual-mode sweep, including odd counts (R7)
    for (int t = 0; t <= 97; t++) begin
      cfg(1, 1, t);
      for (int i = 0; i < 4; i++) push(rnd16(), rnd16(), "R6 dual sweep");
    end
    cfg(1, 1, 7);
    @(negedge clk);
    chk(cfg_err == 1, "R7 odd dual count flagged", longint'(cfg_err), 1);
    cfg(1, 0, 8);
    repeat (2) @(negedge clk);
    chk(cfg_err == 1, "R7 flag sticky", longint'(cfg_err), 1);

    // R8 rounding half up
    for (int k = 0; k < 96; k++) wcoef(k, 0);
    wcoef(0, 1);
    cfg(1, 0, 1);
    push(16384, 0, "R8 +0.5 rounds up");
    push(16384, 0, "R8 +0.5 rounds up");
    push(-16384, 0, "R8 -0.5 rounds to 0");
    push(-16384, 0, "R8 -0.5 rounds to 0");
    push(-16385, 0, "R8 below -0.5");
    push(-16385, 0, "R8 below -0.5");
    push(16383, 0, "R8 below +0.5");
    push(16383, 0, "R8 below +0.5");

    // R10 most negative coefficient
    wcoef(0, -65536);
    push(32767, 0, "R10 min coefficient");
    push(32767, 0, "R10 min coefficient");

    // R9 saturation on both rails, single and dual
    for (int k = 0; k < 96; k++) wcoef(k, 65535);
    cfg(1, 0, 96);
    for (int i = 0; i < 4; i++) push(32767, 32767, "R9 positive rail");
    for (int i = 0; i < 4; i++) push(-32768, -32768, "R9 negative rail");
    cfg(1, 1, 96);
    for (int i = 0; i < 4; i++) push(32767, -32768, "R9 dual rails");

    // R4 back to bypass
    cfg(0, 1, 96);
    for (int i = 0; i < 6; i++) push(rnd16(), rnd16(), "R4 bypass");

    // R3 idle gaps leave history intact
    for (int k = 0; k < 96; k++) wcoef(k, rnd17());
    cfg(1, 1, 96);
    for (int i = 0; i < 4; i++) begin
      repeat (3) @(negedge clk);
      push(rnd16(), rnd16(), "R3 idle gaps");
    end

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule